// File: doc/BRIEF.md
# Soft-Start Reference Sequencer with Hiccup Protection

This block drives the start-up of a synchronous buck converter. It produces a stepped reference code for an external DAC. After every start the code climbs from zero to full scale one step at a time, and then it stays fixed. The block also tells the gate-drive sequencer whether it may switch, through a run signal. Low means the sequencer must hold the high-side switch off.

The block watches four conditions: the enable input, an undervoltage flag with hysteresis on the supply code, an over-temperature flag with hysteresis on the temperature code, and an over-current flag. The over-current flag is only looked at inside the sequencer's low-side conduction window, and only after a blanking interval at the start of that window. When a check trips, the converter enters hiccup: switching stops for one full step interval, and then the ramp starts again from zero.

The current-limit threshold code folds back linearly with the feedback code. A one-hot status word reports the operating state.

Top module: `softstart_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it, `refCode` is 0, `runEn` is 0 and `status` is 4'b1000 (fault). `limitCode` resets to `LIM_LO`.
- R2: When the block leaves the off state with no fault present, `status` becomes 4'b0001 (ramping) and `runEn` becomes 1. `refCode` starts at 0 and rises by exactly one every `STEP_CYCLES` clock cycles.
- R3: When `refCode` reaches `FULL_CODE` it holds that value. One cycle later `status` becomes 4'b0010 (regulating), and no further steps occur.
- R4: `ocFlag` has no effect while `lowSideOn` is low. It also has no effect on the first `BLANK_CYCLES` rising clock edges of each `lowSideOn` window.
- R5: `ocFlag` high while `lowSideOn` is high, on an edge after the blanking interval, with the converter ramping or regulating, has a defined result. From the next cycle `runEn` is 0, `refCode` is 0 and `status` is 4'b0100 (hiccup).
- R6: Hiccup lasts exactly `STEP_CYCLES` cycles. The block then returns to ramping with `refCode` 0.
- R7: `limitCode` equals LIM_LO + floor((LIM_HI-LIM_LO)*fbCode/(2^FB_W-1)). It is registered, so it follows `fbCode` one cycle later.
- R8: `enable` low forces the off state on the next clock: `runEn` 0, `refCode` 0, `status` 4'b1000. When `enable` returns high, the ramp restarts from 0.
- R9: The undervoltage lock sets when `supplyCode` < `UV_FALL` and clears when `supplyCode` >= `UV_RISE`. It keeps its value in between. The lock forces the off state two cycles after the input change, and release restarts the ramp.
- R10: The thermal lock sets when `tempCode` >= `OT_TRIP` and clears when `tempCode` <= `OT_REL`. It keeps its value in between, and has the same two-cycle effect as R9.
- R11: Outside reset, exactly one bit of `status` is set. The bits are: bit0 ramping, bit1 regulating, bit2 hiccup, bit3 fault or off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High to run, low to shut down (a pad pull-up makes an open pin read high) |
| supplyCode | input | SUP_W | Digitized control-supply voltage |
| tempCode | input | TEMP_W | Digitized die temperature |
| fbCode | input | FB_W | Digitized feedback level for foldback |
| lowSideOn | input | 1 | Low-side conduction window from the sequencer |
| ocFlag | input | 1 | Current sense above threshold |
| refCode | output | REF_W | Soft-start reference step index |
| runEn | output | 1 | 1 = sequencer may switch, 0 = force high side off |
| limitCode | output | LIM_W | Folded-back current-limit threshold code |
| status | output | 4 | One-hot state: ramping, regulating, hiccup, fault |

## Verification
The hardest case is the blanking edge. An over-current flag that arrives on the last blanked edge of a low-side window must be ignored, while the same flag one edge later must trip. The stimulus opens a window with the flag already high and closes it after exactly `BLANK_CYCLES` edges, then repeats the pattern with the window held one edge longer. Trips are applied both in regulation and part-way up a ramp, so the return to zero is observed from two different reference values. The hysteresis bands are exercised by stepping the codes into the dead band from either side.

// File: rtl/ssguard_pkg.sv
package ssguard_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RAMP   = 2'd1,
    ST_REG    = 2'd2,
    ST_HICCUP = 2'd3
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRef;
    logic clrTimer;
    logic runTimer;
    logic rampEn;
  } rampStrobe_t;

  localparam int STAT_W     = 4;
  localparam int STAT_RAMP  = 0;
  localparam int STAT_REG   = 1;
  localparam int STAT_HIC   = 2;
  localparam int STAT_FAULT = 3;
endpackage

// File: rtl/ssguard_hyst.sv
module ssguard_hyst #(
  parameter int W       = 8,
  parameter int SET_LVL = 106,
  parameter int CLR_LVL = 108,
  parameter bit ABOVE   = 1'b0,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] code,
  output logic         flag
);
  localparam logic [W-1:0] SET_C = W'(SET_LVL);
  localparam logic [W-1:0] CLR_C = W'(CLR_LVL);

  logic setCond, clrCond;

  generate
    if (ABOVE) begin : g_above
      // trips high, releases at or below the lower level
      assign setCond = code >= SET_C;
      assign clrCond = code <= CLR_C;
      // R10: inside the band the flag keeps its value
      a_r10_band_hold: assert property (@(posedge clk) disable iff (!rstN)
        (flag && code > CLR_C) |=> flag);
      a_r10_band_idle: assert property (@(posedge clk) disable iff (!rstN)
        (!flag && code < SET_C) |=> !flag);
    end else begin : g_below
      // trips low, releases at or above the upper level
      assign setCond = code < SET_C;
      assign clrCond = code >= CLR_C;
      // R9: inside the band the flag keeps its value
      a_r9_band_hold: assert property (@(posedge clk) disable iff (!rstN)
        (flag && code < CLR_C) |=> flag);
      a_r9_band_idle: assert property (@(posedge clk) disable iff (!rstN)
        (!flag && code >= SET_C) |=> !flag);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flag <= RST_VAL;
    else if (setCond) flag <= 1'b1;
    else if (clrCond) flag <= 1'b0;
  end
endmodule

// File: rtl/ssguard_dpath.sv
module ssguard_dpath
  import ssguard_pkg::*;
#(
  parameter int REF_W        = 7,
  parameter int FULL_CODE    = 83,
  parameter int STEP_CYCLES  = 7200,
  parameter int BLANK_CYCLES = 15,
  parameter int FB_W         = 8,
  parameter int LIM_W        = 8,
  parameter int LIM_LO       = 48,
  parameter int LIM_HI       = 130
) (
  input  logic             clk,
  input  logic             rstN,
  input  rampStrobe_t      strb,
  input  logic             lowSideOn,
  input  logic             ocFlag,
  input  logic [FB_W-1:0]  fbCode,
  output logic [REF_W-1:0] refCode,
  output logic [LIM_W-1:0] limitCode,
  output logic             timerLast,
  output logic             atFull,
  output logic             tripBlanked
);
  localparam int TMR_W    = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int BLK_W    = $clog2(BLANK_CYCLES + 1);
  localparam int LIM_SPAN = LIM_HI - LIM_LO;
  localparam int FB_MAX   = (2 ** FB_W) - 1;
  localparam int PROD_W   = LIM_W + FB_W;

  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STEP_CYCLES - 1);
  localparam logic [BLK_W-1:0] BLK_END  = BLK_W'(BLANK_CYCLES);
  localparam logic [REF_W-1:0] REF_FULL = REF_W'(FULL_CODE);

  logic [TMR_W-1:0]  stepTimer;
  logic [BLK_W-1:0]  blankCnt;
  logic [PROD_W-1:0] foldProd, foldQuot;
  logic [LIM_W-1:0]  limitNext;

  // ---- step interval timer ----
  assign timerLast = (stepTimer == TMR_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stepTimer <= '0;
    else if (strb.clrTimer) stepTimer <= '0;
    else if (strb.runTimer) stepTimer <= timerLast ? '0 : stepTimer + 1'b1;
  end

  // ---- staircase reference ----
  assign atFull = (refCode == REF_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  refCode <= '0;
    else if (strb.clrRef)                       refCode <= '0;
    else if (strb.rampEn && timerLast && !atFull) refCode <= refCode + 1'b1;
  end

  // ---- blanked current check ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 blankCnt <= '0;
    else if (!lowSideOn)       blankCnt <= '0;
    else if (blankCnt != BLK_END) blankCnt <= blankCnt + 1'b1;
  end

  assign tripBlanked = lowSideOn && ocFlag && (blankCnt == BLK_END);

  // ---- foldback threshold ----
  assign foldProd  = PROD_W'(LIM_SPAN) * PROD_W'(fbCode);
  assign foldQuot  = foldProd / PROD_W'(FB_MAX);
  assign limitNext = LIM_W'(foldQuot) + LIM_W'(LIM_LO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) limitCode <= LIM_W'(LIM_LO);
    else       limitCode <= limitNext;
  end

  // R2: the reference moves only by one step up or back to zero
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refCode) |-> (refCode == '0 || refCode == REF_W'($past(refCode) + 1'b1)));
  // R3: full scale is held until the control clears it
  a_r3_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    (atFull && !strb.clrRef) |=> atFull);
  // R4: the first edge of a window is always blanked
  a_r4_blank_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowSideOn) |-> !tripBlanked);
  // R7: threshold stays between its end values
  a_r7_limit_range: assert property (@(posedge clk) disable iff (!rstN)
    (limitCode >= LIM_W'(LIM_LO)) && (limitCode <= LIM_W'(LIM_HI)));
endmodule

// File: rtl/ssguard_ctrl.sv
module ssguard_ctrl
  import ssguard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              uvLock,
  input  logic              otHot,
  input  logic              tripBlanked,
  input  logic              timerLast,
  input  logic              atFull,
  output rampStrobe_t       strb,
  output logic              runEn,
  output logic [STAT_W-1:0] status
);
  ctlState_t state, stateNext;
  logic faultNow, moved, timedState;

  assign faultNow = !enable || uvLock || otHot;

  always_comb begin
    stateNext = state;
    case (state)
      ST_OFF:    if (!faultNow)  stateNext = ST_RAMP;
      ST_RAMP:   if (tripBlanked) stateNext = ST_HICCUP;
                 else if (atFull) stateNext = ST_REG;
      ST_REG:    if (tripBlanked) stateNext = ST_HICCUP;
      ST_HICCUP: if (timerLast)   stateNext = ST_RAMP;
      default:   stateNext = ST_OFF;
    endcase
    if (faultNow) stateNext = ST_OFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign moved      = (stateNext != state);
  assign timedState = (state == ST_RAMP) || (state == ST_HICCUP);

  always_comb begin
    strb.clrRef   = (stateNext == ST_OFF) || (stateNext == ST_HICCUP);
    strb.clrTimer = moved || !timedState;
    strb.runTimer = !moved && timedState;
    strb.rampEn   = !moved && (state == ST_RAMP);
  end

  assign runEn = (state == ST_RAMP) || (state == ST_REG);

  always_comb begin
    status = '0;
    case (state)
      ST_RAMP:   status[STAT_RAMP]  = 1'b1;
      ST_REG:    status[STAT_REG]   = 1'b1;
      ST_HICCUP: status[STAT_HIC]   = 1'b1;
      default:   status[STAT_FAULT] = 1'b1;
    endcase
  end

  // R5: an accepted trip removes permission to switch at once
  a_r5_trip_stops: assert property (@(posedge clk) disable iff (!rstN)
    (tripBlanked && runEn) |=> !runEn);
  // R6: hiccup only ever hands over to a ramp or to shutdown
  a_r6_hiccup_exit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[STAT_HIC]) |-> (status[STAT_RAMP] || status[STAT_FAULT]));
  // R8: enable low shuts the converter down on the next edge
  a_r8_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!runEn && status[STAT_FAULT]));
  // R11: one status bit at a time
  a_r11_one_state: assert property (@(posedge clk) disable iff (!rstN)
    $countones(status) == 1);
endmodule

// File: rtl/softstart_guard.sv
module softstart_guard
  import ssguard_pkg::*;
#(
  parameter int STEP_CYCLES  = 7200,
  parameter int BLANK_CYCLES = 15,
  parameter int FULL_CODE    = 83,
  parameter int REF_W        = 7,
  parameter int SUP_W        = 8,
  parameter int UV_RISE      = 108,
  parameter int UV_FALL      = 106,
  parameter int TEMP_W       = 8,
  parameter int OT_TRIP      = 155,
  parameter int OT_REL       = 145,
  parameter int FB_W         = 8,
  parameter int LIM_W        = 8,
  parameter int LIM_LO       = 48,
  parameter int LIM_HI       = 130
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [SUP_W-1:0]  supplyCode,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [FB_W-1:0]   fbCode,
  input  logic              lowSideOn,
  input  logic              ocFlag,
  output logic [REF_W-1:0]  refCode,
  output logic              runEn,
  output logic [LIM_W-1:0]  limitCode,
  output logic [3:0]        status
);
  rampStrobe_t strb;
  logic uvLock, otHot, tripBlanked, timerLast, atFull;

  ssguard_hyst #(.W(SUP_W), .SET_LVL(UV_FALL), .CLR_LVL(UV_RISE),
                 .ABOVE(1'b0), .RST_VAL(1'b1)) u_uv (
    .clk(clk), .rstN(rstN), .code(supplyCode), .flag(uvLock));

  ssguard_hyst #(.W(TEMP_W), .SET_LVL(OT_TRIP), .CLR_LVL(OT_REL),
                 .ABOVE(1'b1), .RST_VAL(1'b0)) u_ot (
    .clk(clk), .rstN(rstN), .code(tempCode), .flag(otHot));

  ssguard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .uvLock(uvLock), .otHot(otHot),
    .tripBlanked(tripBlanked), .timerLast(timerLast), .atFull(atFull),
    .strb(strb), .runEn(runEn), .status(status));

  ssguard_dpath #(.REF_W(REF_W), .FULL_CODE(FULL_CODE), .STEP_CYCLES(STEP_CYCLES),
                  .BLANK_CYCLES(BLANK_CYCLES), .FB_W(FB_W), .LIM_W(LIM_W),
                  .LIM_LO(LIM_LO), .LIM_HI(LIM_HI)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .lowSideOn(lowSideOn), .ocFlag(ocFlag),
    .fbCode(fbCode), .refCode(refCode), .limitCode(limitCode),
    .timerLast(timerLast), .atFull(atFull), .tripBlanked(tripBlanked));
endmodule

// File: tb/softstart_guard_bench.sv
module softstart_guard_bench;
  localparam int S    = 4;
  localparam int B    = 3;
  localparam int FULL = 83;

  // field selectors for the scoreboard
  localparam int F_REF = 0, F_RUN = 1, F_STAT = 2, F_LIM = 3;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, lowSideOn = 1'b0, ocFlag = 1'b0;
  logic [7:0] supplyCode = 8'd120, tempCode = 8'd25, fbCode = 8'd0;
  logic [6:0] refCode;
  logic       runEn;
  logic [7:0] limitCode;
  logic [3:0] status;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  int    qCyc[$];
  int    qField[$];
  int    qExp[$];
  string qTag[$];

  softstart_guard #(.STEP_CYCLES(S), .BLANK_CYCLES(B)) u_softstart_guard (
    .clk(clk), .rstN(rstN), .enable(enable), .supplyCode(supplyCode),
    .tempCode(tempCode), .fbCode(fbCode), .lowSideOn(lowSideOn), .ocFlag(ocFlag),
    .refCode(refCode), .runEn(runEn), .limitCode(limitCode), .status(status));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int actualOf(int f);
    case (f)
      F_REF:   return int'(refCode);
      F_RUN:   return int'(runEn);
      F_STAT:  return int'(status);
      default: return int'(limitCode);
    endcase
  endfunction

  function automatic string nameOf(int f);
    case (f)
      F_REF:   return "refCode";
      F_RUN:   return "runEn";
      F_STAT:  return "status";
      default: return "limitCode";
    endcase
  endfunction

  // R7 expectation from the stated formula
  function automatic int expLimit(int fb);
    return 48 + ((130 - 48) * fb) / 255;
  endfunction

  task automatic expectAt(input int d, input int f, input int v, input string tag);
    qCyc.push_back(cyc + d);
    qField.push_back(f);
    qExp.push_back(v);
    qTag.push_back(tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every item that falls due in this cycle
  always @(negedge clk) begin
    for (int i = qCyc.size() - 1; i >= 0; i--) begin
      if (qCyc[i] == cyc) begin
        checks++;
        if (actualOf(qField[i]) != qExp[i]) begin
          fails++;
          $display("FAIL %s: %s actual %0d expected %0d at cycle %0d",
                   qTag[i], nameOf(qField[i]), actualOf(qField[i]), qExp[i], cyc);
        end
        qCyc.delete(i); qField.delete(i); qExp.delete(i); qTag.delete(i);
      end
    end
    if (rstN && !done) begin
      checks++;
      if ($countones(status) != 1) begin  // R11
        fails++;
        $display("FAIL R11: status actual %b expected one-hot", status);
      end
    end
  end

  task automatic fold(input int fb);
    fbCode = 8'(fb);
    expectAt(1, F_LIM, expLimit(fb), "R7");
    tick(2);
  endtask

  initial begin
    // R1 reset state
    expectAt(1, F_REF, 0, "R1");
    expectAt(1, F_RUN, 0, "R1");
    expectAt(1, F_STAT, 8, "R1");
    expectAt(1, F_LIM, 48, "R1");
    tick(3);
    rstN = 1'b1;
    expectAt(1, F_STAT, 8, "R1");
    tick(2);

    // R2 / R3: full ramp
    enable = 1'b1;
    expectAt(1, F_STAT, 1, "R2");
    expectAt(1, F_RUN, 1, "R2");
    expectAt(1, F_REF, 0, "R2");
    expectAt(S, F_REF, 0, "R2");
    expectAt(S + 1, F_REF, 1, "R2");
    expectAt(2 * S + 1, F_REF, 2, "R2");
    expectAt(FULL * S, F_REF, FULL - 1, "R3");
    expectAt(FULL * S + 1, F_REF, FULL, "R3");
    expectAt(FULL * S + 1, F_STAT, 1, "R3");
    expectAt(FULL * S + 2, F_STAT, 2, "R3");
    expectAt(FULL * S + 2 + 6 * S, F_REF, FULL, "R3");
    tick(FULL * S + 3 + 6 * S);

    // R7 foldback
    fold(255);
    fold(128);
    fold(37);
    fold(0);

    // R4: window closed on the last blanked edge, flag high throughout
    lowSideOn = 1'b1; ocFlag = 1'b1;
    tick(B);
    lowSideOn = 1'b0;
    expectAt(2, F_RUN, 1, "R4");
    expectAt(2, F_STAT, 2, "R4");
    tick(3);
    // R4: flag without a window
    ocFlag = 1'b1;
    expectAt(6, F_RUN, 1, "R4");
    expectAt(6, F_REF, FULL, "R4");
    tick(7);
    ocFlag = 1'b0;
    tick(2);

    // R5 / R6: trip from regulation, one edge after blanking
    lowSideOn = 1'b1; ocFlag = 1'b1;
    expectAt(B, F_STAT, 2, "R5");
    expectAt(B + 1, F_STAT, 4, "R5");
    expectAt(B + 1, F_RUN, 0, "R5");
    expectAt(B + 1, F_REF, 0, "R5");
    expectAt(B + S, F_STAT, 4, "R6");
    expectAt(B + S, F_RUN, 0, "R6");
    expectAt(B + 1 + S, F_STAT, 1, "R6");
    expectAt(B + 1 + S, F_REF, 0, "R6");
    expectAt(B + 1 + 2 * S, F_REF, 1, "R6");
    tick(B + 1);
    lowSideOn = 1'b0; ocFlag = 1'b0;
    tick(6 * S);

    // R5: trip part-way up a ramp
    lowSideOn = 1'b1; ocFlag = 1'b1;
    expectAt(B, F_STAT, 1, "R5");
    expectAt(B + 1, F_REF, 0, "R5");
    expectAt(B + 1, F_STAT, 4, "R5");
    tick(B + 1);
    lowSideOn = 1'b0; ocFlag = 1'b0;
    tick(S + 3);

    // R8 enable
    enable = 1'b0;
    expectAt(1, F_RUN, 0, "R8");
    expectAt(1, F_REF, 0, "R8");
    expectAt(1, F_STAT, 8, "R8");
    tick(5);
    enable = 1'b1;
    expectAt(1, F_STAT, 1, "R8");
    expectAt(1, F_REF, 0, "R8");
    expectAt(S + 1, F_REF, 1, "R8");
    tick(S + 3);

    // R9 undervoltage hysteresis
    supplyCode = 8'd107;
    expectAt(3, F_STAT, 1, "R9");
    tick(4);
    supplyCode = 8'd105;
    expectAt(1, F_STAT, 1, "R9");
    expectAt(2, F_STAT, 8, "R9");
    expectAt(2, F_RUN, 0, "R9");
    tick(3);
    supplyCode = 8'd107;
    expectAt(4, F_STAT, 8, "R9");
    tick(5);
    supplyCode = 8'd108;
    expectAt(2, F_STAT, 1, "R9");
    expectAt(2, F_REF, 0, "R9");
    tick(3);

    // R10 thermal hysteresis
    tempCode = 8'd154;
    expectAt(3, F_STAT, 1, "R10");
    tick(4);
    tempCode = 8'd155;
    expectAt(1, F_STAT, 1, "R10");
    expectAt(2, F_STAT, 8, "R10");
    tick(3);
    tempCode = 8'd146;
    expectAt(4, F_STAT, 8, "R10");
    tick(5);
    tempCode = 8'd145;
    expectAt(2, F_STAT, 1, "R10");
    expectAt(2, F_REF, 0, "R10");
    tick(4);

    if (qCyc.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items pending expected 0", qCyc.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule